// File: doc/BRIEF.md
# Frame Transmit DMA Engine (Memory to Serial Link)

This engine moves a frame that software has already built in memory out to a serial-storage link layer. A single start pulse hands it a byte base address, a length in 32-bit words and a flag that says whether the frame carries data. The engine then reads memory over an AXI4 read master with a 256-bit data bus and presents the content one 32-bit word at a time on a valid/ready transmit port. That port marks the first and last word of the frame.

All memory reads use fixed bursts of sixteen 256-bit beats (512 bytes). The returned beats go into a wide FIFO. A word unpacker on the link side takes beats from that FIFO whenever it holds any and splits each beat into eight words, least-significant word first. The request side keeps a credit count so that a burst is only requested when the FIFO can hold all of it. Read data is therefore never held back. When the flag marks a data frame, the engine puts a fixed header word in front of the memory words itself. Any words fetched past the programmed length, up to the end of the last burst, are read out of the FIFO and dropped without being shown to the link.

Top module: `fis_tx_dma`

## Requirements
- R1: While reset is asserted and until the first accepted start, `m_ar_valid_o`, `tx_valid_o`, `done_o` and `busy_o` are all 0.
- R2: A transfer of N words issues exactly ceil(N/128) read requests. Each has length code 15 (16 beats), size code 5 (32-byte beats) and burst type 1 (incrementing). Request k (counting from 0) carries address base + 512*k.
- R3: A read request is issued only when the FIFO occupancy plus the beats requested but not yet returned, plus 16, does not exceed the FIFO depth (32 beats by default). With the link fully stalled, a non-data transfer requests exactly 32 beats and then stops. `m_r_ready_o` is high whenever read data is offered, and the beats requested but not returned never exceed the depth.
- R4: Once `m_ar_valid_o` is high without `m_ar_ready_i`, it stays high with the same address until accepted.
- R5: Memory words reach the link in ascending address order. Within a 256-bit beat, bits [31:0] go first and bits [255:224] go last.
- R6: When `data_fis_i` is 1 at start, the first word sent is 0x00000046 with `tx_sof_o` set, followed by the N memory words (N+1 words in total).
- R7: When `data_fis_i` is 0 at start, exactly the N memory words are sent, unchanged, and the first one has `tx_sof_o` set.
- R8: `tx_eof_o` is set on the last word of the frame and on no other word. No word is presented after the end-of-frame word is accepted, even when the last burst fetched more than N words.
- R9: `busy_o` is high from the cycle after an accepted start until the cycle in which `done_o` pulses. `done_o` is high for exactly one cycle per transfer, only after the end-of-frame word has been accepted and all fetched beats have been absorbed.
- R10: A start pulse while `busy_o` is high is ignored, and so is a start with a word count of 0. Neither causes a read request or a transmit word.
- R11: While `tx_valid_o` is high and `tx_ready_i` is low, `tx_valid_o`, `tx_data_o`, `tx_sof_o` and `tx_eof_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle start pulse |
| base_addr_i | input | 32 | Byte address of the first memory word |
| word_cnt_i | input | 16 | Number of 32-bit memory words to send |
| data_fis_i | input | 1 | 1: prepend the data header word; 0: send memory as is |
| m_ar_valid_o | output | 1 | Read address valid |
| m_ar_ready_i | input | 1 | Read address ready |
| m_ar_addr_o | output | 32 | Read burst byte address |
| m_ar_len_o | output | 8 | Burst length code (beats minus one) |
| m_ar_size_o | output | 3 | Beat size code |
| m_ar_burst_o | output | 2 | Burst type code |
| m_r_valid_i | input | 1 | Read data valid |
| m_r_ready_o | output | 1 | Read data ready |
| m_r_data_i | input | 256 | Read data beat |
| tx_valid_o | output | 1 | Transmit word valid |
| tx_ready_i | input | 1 | Link accepts the word |
| tx_data_o | output | 32 | Transmit word |
| tx_sof_o | output | 1 | First word of the frame |
| tx_eof_o | output | 1 | Last word of the frame |
| done_o | output | 1 | One-cycle completion pulse |
| busy_o | output | 1 | Transfer in progress |

## Verification
The bench targets lengths on both sides of the beat and burst boundaries: 1, 8, 9, 128 and 129 words. At these lengths a wrong burst count, an off-by-one end-of-frame flag, or tail words leaking past the length shows up as an extra or missing word, a misplaced flag, or a missing completion pulse. A fully stalled link tests the request credit. A design that counts only the FIFO occupancy and forgets bursts still in flight would request more than 32 beats and then either drop data or hold back read data. The bench also sends a second start in the middle of a transfer and a start with a zero length. A design that accepts either would issue extra requests or send stray words. Randomised ready patterns on all three handshakes check the header placement, the least-significant-word-first order and the hold rules under back-pressure.

// File: rtl/fis_tx_pkg.sv
package fis_tx_pkg;

    localparam logic [1:0]  AXI_BURST_INCR = 2'b01;
    localparam logic [31:0] DATA_HDR_WORD  = 32'h0000_0046;

    typedef enum logic [1:0] {
        UP_IDLE,
        UP_HDR,
        UP_WORDS,
        UP_DRAIN
    } up_state_e;

endpackage

// File: rtl/fis_wide_fifo.sv
module fis_wide_fifo #(
    parameter  int W     = 256,
    parameter  int DEPTH = 32,
    localparam int PW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic          full,
    output logic          empty,
    output logic [CW-1:0] count
);

    typedef struct packed {
        logic [PW-1:0] wp;
        logic [PW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t s_d, s_q;
    logic [W-1:0] mem [DEPTH];
    logic push_ok, pop_ok;

    assign full  = (s_q.cnt == CW'(DEPTH));
    assign empty = (s_q.cnt == '0);
    assign count = s_q.cnt;
    assign rdata = mem[s_q.rp];
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;

    always_comb begin
        s_d = s_q;
        if (push_ok) s_d.wp = s_q.wp + PW'(1);
        if (pop_ok)  s_d.rp = s_q.rp + PW'(1);
        s_d.cnt = s_q.cnt + CW'(push_ok) - CW'(pop_ok);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // Storage array carries no reset; occupancy is tracked by s_q.
    always_ff @(posedge clk) begin
        if (push_ok) mem[s_q.wp] <= wdata;
    end

endmodule

// File: rtl/fis_req_ctrl.sv
module fis_req_ctrl #(
    parameter  int ADDR_W      = 32,
    parameter  int NB_W        = 10,
    parameter  int FCW         = 6,
    parameter  int FIFO_DEPTH  = 32,
    parameter  int BURST_LEN   = 16,
    parameter  int BURST_BYTES = 512,
    localparam int OW          = $clog2(FIFO_DEPTH + BURST_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] base,
    input  logic [NB_W-1:0]   bursts,
    input  logic              ar_ready,
    input  logic              r_fire,
    input  logic [FCW-1:0]    fifo_count,
    output logic              ar_valid,
    output logic [ADDR_W-1:0] ar_addr
);

    typedef struct packed {
        logic              run;
        logic              arv;
        logic [ADDR_W-1:0] addr;
        logic [NB_W-1:0]   left;
        logic [OW-1:0]     outst;
    } req_st_t;

    req_st_t s_d, s_q;
    logic    ar_fire;
    logic    room;

    assign ar_valid = s_q.arv;
    assign ar_addr  = s_q.addr;
    assign ar_fire  = s_q.arv && ar_ready;
    // Credit: beats already buffered plus beats still in flight plus one burst.
    assign room = (int'(fifo_count) + int'(s_q.outst) + BURST_LEN) <= FIFO_DEPTH;

    always_comb begin
        s_d = s_q;
        s_d.outst = s_q.outst + (ar_fire ? OW'(BURST_LEN) : OW'(0))
                              - (r_fire  ? OW'(1)         : OW'(0));
        if (start) begin
            s_d.run  = 1'b1;
            s_d.arv  = 1'b0;
            s_d.addr = base;
            s_d.left = bursts;
        end else if (s_q.run) begin
            if (s_q.arv) begin
                if (ar_ready) begin
                    s_d.arv  = 1'b0;
                    s_d.left = s_q.left - NB_W'(1);
                    s_d.addr = s_q.addr + ADDR_W'(BURST_BYTES);
                end
            end else if (s_q.left == '0) begin
                s_d.run = 1'b0;
            end else if (room) begin
                s_d.arv = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/fis_word_unpack.sv
module fis_word_unpack
    import fis_tx_pkg::*;
#(
    parameter  int          DATA_W   = 256,
    parameter  int          WORD_W   = 32,
    parameter  int          CNT_W    = 16,
    parameter  int          NB_W     = 10,
    parameter  int          BURST_LEN = 16,
    parameter  logic [31:0] HDR_WORD = DATA_HDR_WORD,
    localparam int          WPB      = DATA_W / WORD_W,
    localparam int          SW       = $clog2(WPB),
    localparam int          LOG_BL   = $clog2(BURST_LEN),
    localparam int          TB_W     = NB_W + LOG_BL
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              is_data,
    input  logic [NB_W-1:0]   bursts,
    input  logic              fifo_empty,
    input  logic [DATA_W-1:0] fifo_rdata,
    output logic              fifo_pop,
    input  logic              tx_ready,
    output logic              tx_valid,
    output logic [WORD_W-1:0] tx_data,
    output logic              tx_sof,
    output logic              tx_eof,
    output logic              busy,
    output logic              done
);

    typedef struct packed {
        up_state_e         st;
        logic [DATA_W-1:0] beat;
        logic              bvld;
        logic [SW-1:0]     sel;
        logic [CNT_W-1:0]  sent;
        logic [CNT_W-1:0]  last;
        logic [TB_W-1:0]   popped;
        logic [TB_W-1:0]   total;
        logic              dfis;
        logic              done;
    } up_st_t;

    up_st_t s_d, s_q;
    logic   fire;
    logic   sel_end;

    assign sel_end  = (s_q.sel == SW'(WPB - 1));
    assign tx_valid = (s_q.st == UP_HDR) || ((s_q.st == UP_WORDS) && s_q.bvld);
    assign tx_data  = (s_q.st == UP_HDR) ? WORD_W'(HDR_WORD)
                                         : s_q.beat[int'(s_q.sel)*WORD_W +: WORD_W];
    assign tx_sof   = (s_q.st == UP_HDR) ||
                      ((s_q.st == UP_WORDS) && (s_q.sent == '0) && !s_q.dfis);
    assign tx_eof   = (s_q.st == UP_WORDS) && (s_q.sent == s_q.last);
    assign fire     = tx_valid && tx_ready;
    assign busy     = (s_q.st != UP_IDLE);
    assign done     = s_q.done;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        fifo_pop = 1'b0;
        unique case (s_q.st)
            UP_IDLE: begin
                if (start) begin
                    s_d.st     = is_data ? UP_HDR : UP_WORDS;
                    s_d.dfis   = is_data;
                    s_d.bvld   = 1'b0;
                    s_d.sel    = '0;
                    s_d.sent   = '0;
                    s_d.last   = cnt - CNT_W'(1);
                    s_d.popped = '0;
                    s_d.total  = TB_W'(bursts) << LOG_BL;
                end
            end
            UP_HDR: begin
                if (fire) s_d.st = UP_WORDS;
                // Preload the first beat while the header is on the link.
                if (!s_q.bvld && !fifo_empty) begin
                    fifo_pop = 1'b1;
                    s_d.beat = fifo_rdata;
                    s_d.bvld = 1'b1;
                    s_d.sel  = '0;
                end
            end
            UP_WORDS: begin
                if (fire && tx_eof) begin
                    s_d.st   = UP_DRAIN;
                    s_d.bvld = 1'b0;
                end else begin
                    if (fire) begin
                        s_d.sent = s_q.sent + CNT_W'(1);
                        if (sel_end) s_d.bvld = 1'b0;
                        else         s_d.sel  = s_q.sel + SW'(1);
                    end
                    if ((!s_q.bvld || (fire && sel_end)) && !fifo_empty) begin
                        fifo_pop = 1'b1;
                        s_d.beat = fifo_rdata;
                        s_d.bvld = 1'b1;
                        s_d.sel  = '0;
                    end
                end
            end
            UP_DRAIN: begin
                if (s_q.popped == s_q.total) begin
                    s_d.st   = UP_IDLE;
                    s_d.done = 1'b1;
                end else if (!fifo_empty) begin
                    fifo_pop = 1'b1;
                end
            end
            default: s_d.st = UP_IDLE;
        endcase
        if (fifo_pop) s_d.popped = s_q.popped + TB_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/fis_tx_dma.sv
module fis_tx_dma
    import fis_tx_pkg::*;
#(
    parameter  int          ADDR_W      = 32,
    parameter  int          DATA_W      = 256,
    parameter  int          WORD_W      = 32,
    parameter  int          CNT_W       = 16,
    parameter  int          BURST_LEN   = 16,
    parameter  int          FIFO_DEPTH  = 32,
    parameter  logic [31:0] HDR_WORD    = DATA_HDR_WORD,
    localparam int          WPB         = DATA_W / WORD_W,
    localparam int          BEAT_BYTES  = DATA_W / 8,
    localparam int          BURST_BYTES = BEAT_BYTES * BURST_LEN,
    localparam int          LOG_WPBURST = $clog2(WPB * BURST_LEN),
    localparam int          NB_W        = CNT_W - LOG_WPBURST + 1,
    localparam int          FCW         = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] base_addr_i,
    input  logic [CNT_W-1:0]  word_cnt_i,
    input  logic              data_fis_i,
    output logic              m_ar_valid_o,
    input  logic              m_ar_ready_i,
    output logic [ADDR_W-1:0] m_ar_addr_o,
    output logic [7:0]        m_ar_len_o,
    output logic [2:0]        m_ar_size_o,
    output logic [1:0]        m_ar_burst_o,
    input  logic              m_r_valid_i,
    output logic              m_r_ready_o,
    input  logic [DATA_W-1:0] m_r_data_i,
    output logic              tx_valid_o,
    input  logic              tx_ready_i,
    output logic [WORD_W-1:0] tx_data_o,
    output logic              tx_sof_o,
    output logic              tx_eof_o,
    output logic              done_o,
    output logic              busy_o
);

    logic              start_ok;
    logic [CNT_W:0]    cnt_round;
    logic [NB_W-1:0]   burst_cnt;
    logic              fifo_full, fifo_empty, fifo_pop, r_fire;
    logic [FCW-1:0]    fifo_count;
    logic [DATA_W-1:0] fifo_rdata;

    assign start_ok  = start_i && !busy_o && (word_cnt_i != '0);
    assign cnt_round = {1'b0, word_cnt_i} + (CNT_W+1)'(WPB * BURST_LEN - 1);
    assign burst_cnt = NB_W'(cnt_round >> LOG_WPBURST);

    assign m_ar_len_o   = 8'(BURST_LEN - 1);
    assign m_ar_size_o  = 3'($clog2(BEAT_BYTES));
    assign m_ar_burst_o = AXI_BURST_INCR;
    assign m_r_ready_o  = !fifo_full;
    assign r_fire       = m_r_valid_i && m_r_ready_o;

    fis_req_ctrl #(
        .ADDR_W(ADDR_W), .NB_W(NB_W), .FCW(FCW), .FIFO_DEPTH(FIFO_DEPTH),
        .BURST_LEN(BURST_LEN), .BURST_BYTES(BURST_BYTES)
    ) u_req (
        .clk(clk), .rst_n(rst_n), .start(start_ok), .base(base_addr_i),
        .bursts(burst_cnt), .ar_ready(m_ar_ready_i), .r_fire(r_fire),
        .fifo_count(fifo_count), .ar_valid(m_ar_valid_o), .ar_addr(m_ar_addr_o)
    );

    fis_wide_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(r_fire), .wdata(m_r_data_i),
        .pop(fifo_pop), .rdata(fifo_rdata), .full(fifo_full),
        .empty(fifo_empty), .count(fifo_count)
    );

    fis_word_unpack #(
        .DATA_W(DATA_W), .WORD_W(WORD_W), .CNT_W(CNT_W), .NB_W(NB_W),
        .BURST_LEN(BURST_LEN), .HDR_WORD(HDR_WORD)
    ) u_unpack (
        .clk(clk), .rst_n(rst_n), .start(start_ok), .cnt(word_cnt_i),
        .is_data(data_fis_i), .bursts(burst_cnt), .fifo_empty(fifo_empty),
        .fifo_rdata(fifo_rdata), .fifo_pop(fifo_pop), .tx_ready(tx_ready_i),
        .tx_valid(tx_valid_o), .tx_data(tx_data_o), .tx_sof(tx_sof_o),
        .tx_eof(tx_eof_o), .busy(busy_o), .done(done_o)
    );

endmodule

// File: rtl/fis_tx_dma_chk.sv
module fis_tx_dma_chk #(
    parameter int ADDR_W = 32,
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              m_ar_valid_o,
    input logic              m_ar_ready_i,
    input logic [ADDR_W-1:0] m_ar_addr_o,
    input logic              m_r_valid_i,
    input logic              m_r_ready_o,
    input logic              tx_valid_o,
    input logic              tx_ready_i,
    input logic [WORD_W-1:0] tx_data_o,
    input logic              tx_sof_o,
    input logic              tx_eof_o,
    input logic              done_o,
    input logic              busy_o
);

    AST_AR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        m_ar_valid_o && !m_ar_ready_i |=> m_ar_valid_o && $stable(m_ar_addr_o)); // R4

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        m_r_valid_i |-> m_r_ready_o); // R3

    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o)
                                      && $stable(tx_sof_o) && $stable(tx_eof_o)); // R11

    AST_EOF_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid_o && tx_ready_i && tx_eof_o |=> !tx_valid_o); // R8

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R9

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o && !tx_valid_o); // R9

    AST_REQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !m_ar_valid_o); // R10

endmodule

bind fis_tx_dma fis_tx_dma_chk #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .m_ar_valid_o(m_ar_valid_o),
    .m_ar_ready_i(m_ar_ready_i), .m_ar_addr_o(m_ar_addr_o),
    .m_r_valid_i(m_r_valid_i), .m_r_ready_o(m_r_ready_o),
    .tx_valid_o(tx_valid_o), .tx_ready_i(tx_ready_i), .tx_data_o(tx_data_o),
    .tx_sof_o(tx_sof_o), .tx_eof_o(tx_eof_o), .done_o(done_o), .busy_o(busy_o)
);

// File: tb/fis_tx_dma_bench.sv
`timescale 1ns/1ps
module fis_tx_dma_bench;

    localparam int DEPTH = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [31:0]  base_addr_i = '0;
    logic [15:0]  word_cnt_i = '0;
    logic         data_fis_i = 1'b0;
    logic         m_ar_valid_o, m_ar_ready_i;
    logic [31:0]  m_ar_addr_o;
    logic [7:0]   m_ar_len_o;
    logic [2:0]   m_ar_size_o;
    logic [1:0]   m_ar_burst_o;
    logic         m_r_valid_i, m_r_ready_o;
    logic [255:0] m_r_data_i;
    logic         tx_valid_o, tx_ready_i, tx_sof_o, tx_eof_o, done_o, busy_o;
    logic [31:0]  tx_data_o;

    always #2.5 clk = ~clk;

    fis_tx_dma u_fis_tx_dma (.*);

    int n_checks = 0, n_fail = 0;
    int ar_pct = 70, r_pct = 70, tx_pct = 70;
    bit stall = 1'b0;
    logic [31:0] exp_base = '0;
    int  exp_total = 0;
    bit  exp_d = 1'b0;
    int  words_base = 0, bursts_base = 0;

    int tot_words = 0, word_err = 0, flag_err = 0, tot_bursts = 0, addr_err = 0;
    int done_cnt = 0, done_early = 0, hold_err = 0, rready_err = 0, outst_err = 0;
    int arhold_err = 0, arv_cycles = 0, txv_cycles = 0, issued = 0, returned = 0;

    logic [31:0] bq [64];
    int bq_wr = 0, bq_rd = 0, beat_i = 0;
    bit ar_wait = 1'b0, tx_wait = 1'b0;
    logic [31:0] ar_prev_addr = '0, tx_prev_data = '0;
    bit tx_prev_sof = 1'b0, tx_prev_eof = 1'b0;

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return (a * 32'h9E37_79B1) ^ 32'hC0DE_0000 ^ {a[9:2], 24'h0};
    endfunction

    function automatic logic [255:0] mem_beat(input logic [31:0] a);
        logic [255:0] b;
        for (int k = 0; k < 8; k++) b[k*32 +: 32] = mem_word(a + 32'(4*k));
        return b;
    endfunction

    function automatic logic [31:0] exp_word(input int idx);
        if (exp_d) return (idx == 0) ? 32'h0000_0046 : mem_word(exp_base + 32'(4*(idx-1)));
        return mem_word(exp_base + 32'(4*idx));
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Memory slave and link sink, all driven at the falling edge.
    always @(negedge clk) begin
        if (!rst_n) begin
            m_ar_ready_i = 1'b0; m_r_valid_i = 1'b0; m_r_data_i = '0; tx_ready_i = 1'b0;
        end else begin
            if (ar_wait && (!m_ar_valid_o || m_ar_addr_o != ar_prev_addr)) arhold_err++;
            m_ar_ready_i = ($urandom % 100) < ar_pct;
            if (m_ar_valid_o) arv_cycles++;
            if (m_ar_valid_o && m_ar_ready_i) begin
                if (m_ar_addr_o != exp_base + 32'(512*(tot_bursts - bursts_base)) ||
                    m_ar_len_o != 8'd15 || m_ar_size_o != 3'd5 || m_ar_burst_o != 2'd1)
                    addr_err++;
                bq[bq_wr % 64] = m_ar_addr_o;
                bq_wr++; tot_bursts++; issued += 16;
            end
            ar_wait = m_ar_valid_o && !m_ar_ready_i;
            ar_prev_addr = m_ar_addr_o;

            m_r_valid_i = 1'b0;
            if (bq_rd != bq_wr && ($urandom % 100) < r_pct) begin
                m_r_valid_i = 1'b1;
                m_r_data_i = mem_beat(bq[bq_rd % 64] + 32'(32*beat_i));
                if (!m_r_ready_o) rready_err++;
                else begin
                    returned++; beat_i++;
                    if (beat_i == 16) begin beat_i = 0; bq_rd++; end
                end
            end
            if (issued - returned > DEPTH) outst_err++;

            if (tx_wait && (!tx_valid_o || tx_data_o != tx_prev_data ||
                            tx_sof_o != tx_prev_sof || tx_eof_o != tx_prev_eof)) hold_err++;
            tx_ready_i = !stall && (($urandom % 100) < tx_pct);
            if (tx_valid_o) txv_cycles++;
            if (tx_valid_o && tx_ready_i) begin
                automatic int idx = tot_words - words_base;
                if (idx >= exp_total || tx_data_o != exp_word(idx)) word_err++;
                if (tx_sof_o != (idx == 0) || tx_eof_o != (idx == exp_total - 1)) flag_err++;
                tot_words++;
            end
            tx_wait = tx_valid_o && !tx_ready_i;
            tx_prev_data = tx_data_o; tx_prev_sof = tx_sof_o; tx_prev_eof = tx_eof_o;

            if (done_o) begin
                done_cnt++;
                if (tot_words - words_base != exp_total) done_early++;
            end
        end
    end

    task automatic run_xfer(input int n, input bit d, input logic [31:0] base,
                            input int stall_cyc, input bit inject);
        int w0, b0, we0, fe0, ae0, d0, de0, he0, re0, oe0, ahe0, iss0, av0, tv0;
        exp_base = base; exp_total = n + int'(d); exp_d = d;
        words_base = tot_words; bursts_base = tot_bursts;
        w0 = tot_words; b0 = tot_bursts; we0 = word_err; fe0 = flag_err; ae0 = addr_err;
        d0 = done_cnt; de0 = done_early; he0 = hold_err; re0 = rready_err;
        oe0 = outst_err; ahe0 = arhold_err; iss0 = issued;
        if (stall_cyc > 0) stall = 1'b1;
        @(negedge clk);
        start_i = 1'b1; base_addr_i = base; word_cnt_i = 16'(n); data_fis_i = d;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o == 1'b1, "R9", "busy after start", longint'(busy_o), 1);
        if (stall_cyc > 0) begin
            repeat (stall_cyc) @(negedge clk);
            check(issued - iss0 == DEPTH, "R3", "beats requested with link stalled",
                  issued - iss0, DEPTH);
            stall = 1'b0;
        end
        if (inject) begin
            repeat (10) @(negedge clk);
            start_i = 1'b1; base_addr_i = base ^ 32'h0010_0000; word_cnt_i = 16'd7;
            data_fis_i = !d;
            @(negedge clk);
            start_i = 1'b0;
        end
        for (int i = 0; i < 40000 && done_cnt == d0; i++) @(negedge clk);
        repeat (4) @(negedge clk);
        check(tot_words - w0 == exp_total, (d ? "R6" : "R7"), "words sent",
              tot_words - w0, exp_total);
        check(word_err == we0, "R5", "word value or order errors", word_err - we0, 0);
        check(flag_err == fe0, "R8", "sof/eof placement errors", flag_err - fe0, 0);
        check(tot_bursts - b0 == (n + 127) / 128, "R2", "burst count",
              tot_bursts - b0, (n + 127) / 128);
        check(addr_err == ae0, "R2", "burst address/shape errors", addr_err - ae0, 0);
        check(done_cnt - d0 == 1, "R9", "done pulses", done_cnt - d0, 1);
        check(done_early == de0, "R9", "done before last word", done_early - de0, 0);
        check(busy_o == 1'b0, "R9", "busy after done", longint'(busy_o), 0);
        check(hold_err == he0, "R11", "tx hold violations", hold_err - he0, 0);
        check(rready_err == re0 && outst_err == oe0, "R3", "read backpressure/credit errors",
              (rready_err - re0) + (outst_err - oe0), 0);
        check(arhold_err == ahe0, "R4", "request hold violations", arhold_err - ahe0, 0);
        if (inject) begin
            av0 = arv_cycles; tv0 = txv_cycles;
            repeat (40) @(negedge clk);
            check(arv_cycles == av0 && txv_cycles == tv0, "R10", "activity after busy start",
                  (arv_cycles - av0) + (txv_cycles - tv0), 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        int av0, tv0;
        void'($urandom(32'h1357_2468));
        repeat (5) @(negedge clk);
        check(!m_ar_valid_o && !tx_valid_o && !done_o && !busy_o, "R1", "outputs in reset",
              {m_ar_valid_o, tx_valid_o, done_o, busy_o}, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(!m_ar_valid_o && !tx_valid_o && !done_o && !busy_o, "R1", "outputs after reset",
              {m_ar_valid_o, tx_valid_o, done_o, busy_o}, 0);

        // R10: zero-length start is ignored.
        av0 = arv_cycles; tv0 = txv_cycles;
        @(negedge clk); start_i = 1'b1; word_cnt_i = '0; data_fis_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        repeat (30) @(negedge clk);
        check(!busy_o && arv_cycles == av0 && txv_cycles == tv0, "R10", "zero-length start",
              (arv_cycles - av0) + (txv_cycles - tv0) + int'(busy_o), 0);

        // Directed boundary lengths.
        run_xfer(1,   1'b0, 32'h0000_1000, 0, 1'b0);
        run_xfer(1,   1'b1, 32'h0000_2000, 0, 1'b0);
        run_xfer(8,   1'b0, 32'h0001_0000, 0, 1'b0);
        run_xfer(9,   1'b1, 32'h0001_4000, 0, 1'b0);
        run_xfer(128, 1'b0, 32'h0002_0000, 0, 1'b0);
        run_xfer(129, 1'b1, 32'h0003_0000, 0, 1'b0);
        tx_pct = 100; r_pct = 100; ar_pct = 100;
        run_xfer(256, 1'b1, 32'h0004_0000, 0, 1'b0);
        // R3: link stalled, credit must cap requests at the FIFO depth.
        tx_pct = 60; r_pct = 90; ar_pct = 90;
        run_xfer(1000, 1'b0, 32'h0010_0000, 400, 1'b0);
        // R10: second start during a transfer.
        run_xfer(300, 1'b1, 32'h0020_0000, 0, 1'b1);

        for (int t = 0; t < 20; t++) begin
            ar_pct = 20 + int'($urandom % 81);
            r_pct  = 20 + int'($urandom % 81);
            tx_pct = 20 + int'($urandom % 81);
            run_xfer(1 + int'($urandom % 700), 1'($urandom % 2),
                     $urandom & 32'h0FFF_FE00, 0, 1'b0);
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule